// File: doc/BRIEF.md
# Cascaded Partial-Result Transfer Controller

This block moves 16-bit partial results between the processing units of a cascade. There is one master and up to six slaves, and they share a single bidirectional bus. Active-low flag lines carry a token from unit to unit. A unit places data on the bus only while it holds the token, and it releases the bus once it has passed the token on. Each slave adds its own local partial result to the value it receives, saturating the sum, and sends the sum onward. The master launches one traversal per frame and receives the accumulated sum from the last slave. It then sends that sum back to every slave on its broadcast flag.

The chain order comes from the wiring alone. The master's start flag feeds the chain input of the first slave. Each slave's pass flag feeds the chain input of the next slave. The pass flag of the last slave returns to the master's collect input. The master's pass flag reaches the collect input of every slave. A unit that works alone loops its start flag into its own collect input and ties its chain input high. Undriven flag and bus lines read high because they have pull-ups.

Top module: `cascade_xfer`

## Requirements
- R1: While rst_ni is low, and in every cycle after a cycle in which sleep_i was sampled high, start_flag_no and pass_flag_no are high and bus_oe_o is low. Sleep also aborts any traversal in progress.
- R2: A master (slave_i low) that samples frame_i high while idle drives local_i on bus_o with bus_oe_o high for two cycles. start_flag_no is low (active) in the second of those two cycles only.
- R3: A slave (slave_i high) captures bus_i at the clock edge where chain_ni is first seen low. From the next cycle it drives the saturated sum of the captured value and local_i for two cycles, with pass_flag_no low in the second cycle.
- R4: The sum is signed two's complement. A result above 32767 becomes 16'h7FFF and a result below -32768 becomes 16'h8000.
- R5: A master that is waiting captures bus_i at the clock edge where collect_ni is first seen low. In the next cycle it presents that value on result_o with result_vld_o high for one cycle. In the same cycle it starts to drive that value for two cycles, with pass_flag_no low in the second cycle.
- R6: A slave captures bus_i at a falling edge of collect_ni and presents the value on result_o with result_vld_o high for one cycle. It does not drive the bus in response.
- R7: If a master that is waiting sees no collect fall within TIMEOUT_CYC cycles after the launch edge, timeout_o goes high and stays high until the next launch, and no broadcast follows.
- R8: bus_oe_o is low whenever the unit is not in a two-cycle drive window. The two flags are never both low.
- R9: frame_i has no effect on a slave, and no effect on a master that is already waiting for its collect flag.
- R10: A collect fall seen by a master that is not waiting does not produce result_vld_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Power-down: clears state, releases the bus, holds the flags high |
| slave_i | input | 1 | 0 = master or stand-alone, 1 = slave |
| frame_i | input | 1 | Frame start pulse (master) |
| chain_ni | input | 1 | Token input from the previous unit, active low |
| collect_ni | input | 1 | Collect or broadcast flag input, active low |
| start_flag_no | output | 1 | Master start flag, active low |
| pass_flag_no | output | 1 | Pass-on or broadcast flag, active low |
| bus_i | input | 16 | Resolved bus value |
| bus_o | output | 16 | Data driven onto the bus |
| bus_oe_o | output | 1 | Bus output enable |
| local_i | input | 16 | Local signed partial result |
| result_o | output | 16 | Final collected sum |
| result_vld_o | output | 1 | One-cycle strobe for result_o |
| timeout_o | output | 1 | Collect flag missing within the timeout window |

## Verification
Every response is registered once. Bus data is due in the cycle after the triggering edge (frame sample, chain fall or collect fall). The flag goes low one cycle later and returns high, with the bus released, in the cycle after that. A collected result shows up in the same cycle as the first broadcast drive. The timeout bit is high right after the TIMEOUT_CYC-th edge following the launch and is still low after the edge before it. The bench drives inputs on falling clock edges and reads outputs on the following falling edge, counting each rising edge on the way. Each check therefore lands on the exact cycle the requirement names.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_DRIVE, TX_FLAG} tx_st_e;
endpackage

// File: rtl/xc_fall_det.sv
module xc_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic line_ni,
  output logic fall_o
);
  logic prev_q;

  // pulled-up line idles high
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    prev_q <= 1'b1;
    else if (clr_i) prev_q <= 1'b1;
    else            prev_q <= line_ni;

  assign fall_o = prev_q & ~line_ni;
endmodule

// File: rtl/xc_sat_add.sv
module xc_sat_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] full;
  assign full = {a_i[W-1], a_i} + {b_i[W-1], b_i};

  always_comb begin
    if (full[W] != full[W-1]) sum_o = full[W] ? NEG_MIN : POS_MAX;
    else                      sum_o = full[W-1:0];
  end
endmodule

// File: rtl/xc_tx.sv
module xc_tx
  import xc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         launch_i,
  input  logic         pass_sel_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] bus_o,
  output logic         oe_o,
  output logic         start_no,
  output logic         pass_no,
  output logic         busy_o
);
  tx_st_e       st_q;
  logic [W-1:0] data_q;
  logic         sel_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      data_q <= '0;
      sel_q  <= 1'b0;
    end else if (clr_i) begin
      st_q   <= TX_IDLE;
    end else if (launch_i) begin
      // a relaunch from the flag cycle keeps the bus driven back to back
      st_q   <= TX_DRIVE;
      data_q <= data_i;
      sel_q  <= pass_sel_i;
    end else begin
      case (st_q)
        TX_DRIVE: st_q <= TX_FLAG;
        default:  st_q <= TX_IDLE;
      endcase
    end

  assign busy_o   = (st_q != TX_IDLE);
  assign oe_o     = busy_o;
  assign bus_o    = data_q;
  assign start_no = ~((st_q == TX_FLAG) & ~sel_q);
  assign pass_no  = ~((st_q == TX_FLAG) & sel_q);
endmodule

// File: rtl/cascade_xfer.sv
module cascade_xfer #(
  parameter int DATA_W      = 16,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              slave_i,
  input  logic              frame_i,
  input  logic              chain_ni,
  input  logic              collect_ni,
  output logic              start_flag_no,
  output logic              pass_flag_no,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  input  logic [DATA_W-1:0] local_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_vld_o,
  output logic              timeout_o
);
  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic chain_fall, col_fall, tx_busy;
  logic launch_m, cap_m, cap_s, fwd_s, tx_go;
  logic [DATA_W-1:0] sum, tx_data;
  logic wait_q, vld_q, tmo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] result_q;

  xc_fall_det u_chain (.clk_i, .rst_ni, .clr_i(sleep_i), .line_ni(chain_ni),   .fall_o(chain_fall));
  xc_fall_det u_coll  (.clk_i, .rst_ni, .clr_i(sleep_i), .line_ni(collect_ni), .fall_o(col_fall));

  xc_sat_add #(.W(DATA_W)) u_add (.a_i(bus_i), .b_i(local_i), .sum_o(sum));

  assign launch_m = ~slave_i & frame_i & ~wait_q & ~tx_busy & ~sleep_i;
  assign cap_m    = ~slave_i & wait_q & col_fall & ~sleep_i;
  assign cap_s    = slave_i & col_fall & ~sleep_i;
  assign fwd_s    = slave_i & chain_fall & ~sleep_i;
  assign tx_go    = launch_m | cap_m | fwd_s;

  always_comb begin
    if (launch_m)   tx_data = local_i;
    else if (cap_m) tx_data = bus_i;
    else            tx_data = sum;
  end

  xc_tx #(.W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .clr_i(sleep_i),
    .launch_i(tx_go), .pass_sel_i(~launch_m), .data_i(tx_data),
    .bus_o, .oe_o(bus_oe_o), .start_no(start_flag_no), .pass_no(pass_flag_no),
    .busy_o(tx_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wait_q <= 1'b0; vld_q <= 1'b0; tmo_q <= 1'b0;
      cnt_q <= '0; result_q <= '0;
    end else if (sleep_i) begin
      wait_q <= 1'b0; vld_q <= 1'b0; tmo_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (launch_m) begin
        wait_q <= 1'b1; cnt_q <= '0; tmo_q <= 1'b0;
      end else if (cap_m) begin
        wait_q <= 1'b0; result_q <= bus_i; vld_q <= 1'b1;
      end else if (wait_q) begin
        if (cnt_q == CNT_LAST) begin
          wait_q <= 1'b0; tmo_q <= 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
      end
      if (cap_s) begin
        result_q <= bus_i; vld_q <= 1'b1;
      end
    end

  assign result_o     = result_q;
  assign result_vld_o = vld_q;
  assign timeout_o    = tmo_q;
endmodule

// File: rtl/cascade_xfer_chk.sv
module cascade_xfer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_i,
  input logic start_flag_no,
  input logic pass_flag_no,
  input logic bus_oe_o,
  input logic result_vld_o,
  input logic timeout_o
);
  always @(negedge clk_i)
    if (!rst_ni)
      assert_reset_idle_R1: assert (start_flag_no && pass_flag_no && !bus_oe_o);

  assert_sleep_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (start_flag_no && pass_flag_no && !bus_oe_o));

  assert_start_after_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_flag_no) |-> $past(bus_oe_o));

  assert_start_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_flag_no |=> start_flag_no);

  assert_pass_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass_flag_no |=> pass_flag_no);

  assert_pass_after_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pass_flag_no) |-> $past(bus_oe_o));

  assert_vld_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_vld_o |=> !result_vld_o);

  assert_flag_needs_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_flag_no || !pass_flag_no) |-> bus_oe_o);

  assert_flags_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!start_flag_no && !pass_flag_no));

  assert_timeout_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (!bus_oe_o && !result_vld_o));
endmodule

bind cascade_xfer cascade_xfer_chk u_chk (
  .clk_i, .rst_ni, .sleep_i, .start_flag_no, .pass_flag_no,
  .bus_oe_o, .result_vld_o, .timeout_o
);

// File: tb/sim_cascade_xfer.sv
module sim_cascade_xfer;
  localparam int CLK_P = 10;
  localparam int TO    = 16;

  logic clk = 1'b0, rst_ni = 1'b0, sleep = 1'b0, slave = 1'b0, frame = 1'b0;
  logic chain_n = 1'b1, tb_col_n = 1'b1, loop_en = 1'b0, tb_oe = 1'b0;
  logic [15:0] tb_bus = '0, local_v = '0;
  logic start_n, pass_n, oe, vld, tmo;
  logic [15:0] bus_o, result, bus_w;
  logic col_n;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  assign col_n = loop_en ? start_n : tb_col_n;
  assign bus_w = oe ? bus_o : (tb_oe ? tb_bus : 16'hFFFF);

  cascade_xfer #(.DATA_W(16), .TIMEOUT_CYC(TO)) u0 (
    .clk_i(clk), .rst_ni, .sleep_i(sleep), .slave_i(slave), .frame_i(frame),
    .chain_ni(chain_n), .collect_ni(col_n), .start_flag_no(start_n),
    .pass_flag_no(pass_n), .bus_i(bus_w), .bus_o, .bus_oe_o(oe),
    .local_i(local_v), .result_o(result), .result_vld_o(vld), .timeout_o(tmo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 start flag in reset", start_n, 1);
    chk("R1 pass flag in reset", pass_n, 1);
    chk("R1 bus released in reset", oe, 0);
    chk("R1 no strobe in reset", vld, 0);
  endtask

  task automatic t_standalone(input logic [15:0] l);
    slave = 0; loop_en = 1; local_v = l;
    frame = 1; step(); frame = 0;
    chk("R2 data cycle oe", oe, 1);
    chk("R2 data cycle value", bus_o, l);
    chk("R2 flag idle in data cycle", start_n, 1);
    step();
    chk("R2 start flag active", start_n, 0);
    chk("R2 data held in flag cycle", bus_o, l);
    step();
    chk("R2 start flag released", start_n, 1);
    chk("R5 result strobe", vld, 1);
    chk("R5 result value", result, l);
    chk("R5 broadcast drive", {oe, bus_o}, {1'b1, l});
    step();
    chk("R5 broadcast pass flag", pass_n, 0);
    chk("R5 strobe one cycle", vld, 0);
    step();
    chk("R8 bus released after broadcast", oe, 0);
    chk("R8 pass flag released", pass_n, 1);
    loop_en = 0;
  endtask

  task automatic t_slave_fwd(input logic [15:0] in, input logic [15:0] l,
                             input logic [15:0] exp, input string req);
    slave = 1; local_v = l;
    tb_bus = in; tb_oe = 1; chain_n = 1; step();
    chain_n = 0; step();
    chain_n = 1; tb_oe = 0;
    chk({req, " forward oe"}, oe, 1);
    chk({req, " forward value"}, bus_o, exp);
    chk({req, " pass idle in data cycle"}, pass_n, 1);
    chk("R3 slave never starts", start_n, 1);
    step();
    chk({req, " pass flag active"}, pass_n, 0);
    chk({req, " value held"}, bus_o, exp);
    step();
    chk("R8 slave releases bus", oe, 0);
    chk("R3 pass flag released", pass_n, 1);
  endtask

  task automatic t_slave_collect(input logic [15:0] v);
    slave = 1; tb_bus = v; tb_oe = 1; tb_col_n = 1; step();
    tb_col_n = 0; step();
    tb_col_n = 1; tb_oe = 0;
    chk("R6 slave result strobe", vld, 1);
    chk("R6 slave result value", result, v);
    chk("R6 slave does not drive", oe, 0);
    step();
    chk("R6 strobe one cycle", vld, 0);
    chk("R6 no drive after collect", oe, 0);
  endtask

  task automatic collect_as_last(input logic [15:0] v);
    tb_bus = v; tb_oe = 1; tb_col_n = 1; step();
    tb_col_n = 0; step();
    tb_col_n = 1; tb_oe = 0;
  endtask

  task automatic t_master_cascade(input logic [15:0] l, input logic [15:0] v);
    slave = 0; loop_en = 0; chain_n = 1; local_v = l;
    frame = 1; step(); frame = 0;
    chk("R2 master drives local", bus_o, l);
    step();
    chk("R2 master start flag", start_n, 0);
    step();
    chk("R8 master releases bus while waiting", oe, 0);
    repeat (3) step();
    collect_as_last(v);
    chk("R5 cascade result strobe", vld, 1);
    chk("R5 cascade result value", result, v);
    chk("R5 broadcast value", bus_o, v);
    step();
    chk("R5 broadcast flag", pass_n, 0);
    step();
    chk("R8 released after cascade", oe, 0);
  endtask

  task automatic t_timeout();
    slave = 0; loop_en = 0; local_v = 16'h0042;
    frame = 1; step(); frame = 0;
    repeat (TO - 1) step();
    chk("R7 no timeout before window end", tmo, 0);
    step();
    chk("R7 timeout raised", tmo, 1);
    chk("R7 no broadcast on timeout", {oe, pass_n}, 2'b01);
    step();
    chk("R7 timeout held", tmo, 1);
    collect_as_last(16'h1234);
    chk("R10 late collect gives no strobe", vld, 0);
    chk("R10 late collect gives no drive", oe, 0);
    frame = 1; step(); frame = 0;
    chk("R7 timeout cleared on launch", tmo, 0);
    repeat (TO + 2) step();
  endtask

  task automatic t_ignore_frame();
    slave = 1; frame = 1; step(); frame = 0;
    chk("R9 slave ignores frame oe", oe, 0);
    step();
    chk("R9 slave ignores frame flag", start_n, 1);
    slave = 0; loop_en = 0; local_v = 16'h0101;
    frame = 1; step(); frame = 0;
    step(); step();
    frame = 1; step(); frame = 0;
    chk("R9 waiting master ignores frame oe", oe, 0);
    step();
    chk("R9 waiting master ignores frame flag", start_n, 1);
    collect_as_last(16'h0BEE);
    chk("R9 traversal still completes", {vld, result}, {1'b1, 16'h0BEE});
    repeat (3) step();
  endtask

  task automatic t_sleep();
    slave = 0; loop_en = 1; local_v = 16'h00AA;
    frame = 1; step(); frame = 0;
    chk("R2 drive before sleep", oe, 1);
    sleep = 1; step();
    chk("R1 sleep releases bus", oe, 0);
    chk("R1 sleep flags high", {start_n, pass_n}, 2'b11);
    step();
    chk("R1 sleep no strobe", vld, 0);
    sleep = 0; step();
    chk("R1 idle after sleep", oe, 0);
    loop_en = 0;
    t_standalone(16'h00AB);
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst_ni = 1; step();
    t_standalone(16'h1357);
    t_standalone(16'hFFFE);
    t_slave_fwd(16'h0064, 16'hFED4, 16'hFF38, "R3");
    t_slave_fwd(16'h7530, 16'h2710, 16'h7FFF, "R4 positive clamp");
    t_slave_fwd(16'h8AD0, 16'hD8F0, 16'h8000, "R4 negative clamp");
    t_slave_fwd(16'h7FFE, 16'h0001, 16'h7FFF, "R4 exact max");
    t_slave_collect(16'h4321);
    t_master_cascade(16'h0011, 16'h5A5A);
    t_timeout();
    t_ignore_frame();
    t_sleep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule